// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block sits between the clock sources of a board clock generator and its output drivers. It gates four groups of clocks: the processor group, the gated bus group, one free-running bus clock, and the auxiliary group (reference, peripheral and interrupt-controller clocks). Three asynchronous, active-low control pins drive the gating: `cpu_stop_n`, `pci_stop_n` and `pwr_dn_n`. The block also drives an enable for the crystal oscillator and the PLLs.

Each group has its own gate. The gate moves the group's run request through a two-stage synchronizer clocked on the falling edge of that group's clock, then ANDs the result with the clock. The enable can change only while the clock is low, so a stopped clock always ends after a full high phase and restarts at a rising edge. Power-down has priority over the two stop pins and is run by a small state machine in the auxiliary clock domain, which stands in for the reference oscillator. The machine has four states. `PS_RUN`: all groups may run. `PS_DRAIN`: the groups are being stopped and the oscillator is still on. `PS_OFF`: the oscillator and PLLs are disabled. `PS_WAKE`: the oscillator is back on and a lock counter runs. The transitions are RUN→DRAIN when a power-down request arrives; DRAIN→OFF after `DRAIN_CYCLES`; OFF→WAKE when the request is released; WAKE→RUN after `WAKE_CYCLES`; and WAKE→DRAIN if power-down returns during the wait. Reset enters `PS_WAKE`.

Top module: `clkstop_ctrl`

## Requirements
- R1: During reset and for at least `WAKE_CYCLES` auxiliary clock cycles after reset release, every clock output stays low and `osc_pll_en` is 1. After that, with all control pins high, every group toggles.
- R2: While `cpu_stop_n` is 0 and power is up, every `cpu_clk_out` bit is held low. Once it returns to 1, the group toggles again.
- R3: While `pci_stop_n` is 0, every `pci_clk_out` bit is held low, and `pci_free_out` keeps toggling.
- R4: `pci_free_out` ignores both stop pins. The two stop pins act independently: each one leaves the other group toggling.
- R5: While `pwr_dn_n` is 0, every output is low whatever the stop pins are, and `osc_pll_en` is 0 once the drain period has ended.
- R6: After `pwr_dn_n` returns to 1, `osc_pll_en` rises, and every clock output stays low for at least `WAKE_CYCLES` auxiliary cycles from that rise. The groups enabled by the stop pins then run.
- R7: A gated output rises only at a rising edge of its source clock and falls only at a falling edge of it. This holds while stopping and while restarting, so no runt pulse appears.
- R8: `aux_clk_out` is stopped only by power-down. Neither stop pin affects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_clk | input | 1 | Processor group source clock |
| pci_clk | input | 1 | Bus group source clock |
| aux_clk | input | 1 | Auxiliary source clock; also clocks the power state machine |
| cpu_stop_n | input | 1 | Active-low request to stop the processor group |
| pci_stop_n | input | 1 | Active-low request to stop the gated bus group |
| pwr_dn_n | input | 1 | Active-low power-down request |
| cpu_clk_out | output | CPU_OUTS | Gated processor clocks |
| pci_clk_out | output | PCI_OUTS | Gated bus clocks |
| pci_free_out | output | 1 | Free-running bus clock, stopped only by power-down |
| aux_clk_out | output | AUX_OUTS | Gated auxiliary clocks |
| osc_pll_en | output | 1 | Oscillator and PLL enable |

## Verification
The bench drives every combination of the three control pins, first in directed steps and then in a seeded random walk. In each settled state it counts rising edges on every output group. This tells apart a group that is wrongly coupled to another group's stop pin from one that is correctly independent, and the free-running clock from the gated bus clocks. A directed power-down release measures the quiet window after the oscillator enable returns, which separates a working lock counter from one that is missing or too short. On every output edge, a monitor compares the edge with the level of the source clock. Any enable change during a high phase, which would cut a pulse short, shows up as a mismatch.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;
    typedef enum logic [1:0] {
        PS_RUN   = 2'd0,
        PS_DRAIN = 2'd1,
        PS_OFF   = 2'd2,
        PS_WAKE  = 2'd3
    } pwr_state_e;
endpackage

// File: rtl/clkstop_gate.sv
`timescale 1ns/1ps
// One gated clock: run request resynchronized on falling edges so the
// enable only moves while the clock is low.
module clkstop_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic clk_o
);
    logic [SYNC_STAGES-1:0] sync_q;

    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], run_i};
        end
    end

    assign clk_o = clk_i & sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/clkstop_pwr_fsm.sv
`timescale 1ns/1ps
// Power sequencing in the auxiliary (reference) domain.
module clkstop_pwr_fsm
    import clkstop_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int DRAIN_CYCLES = 4,
    parameter int WAKE_CYCLES  = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pwr_dn_ni,
    output logic pwr_ok_o,
    output logic osc_en_o
);
    localparam int MAXC = (WAKE_CYCLES > DRAIN_CYCLES) ? WAKE_CYCLES : DRAIN_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] WAKE_LAST  = CW'(WAKE_CYCLES - 1);
    localparam logic [CW-1:0] DRAIN_LAST = CW'(DRAIN_CYCLES - 1);

    logic [SYNC_STAGES-1:0] pd_sync_q;
    logic                   pd_req;
    pwr_state_e             state_q, state_d;
    logic [CW-1:0]          cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pd_sync_q <= '0;
        end else begin
            pd_sync_q <= {pd_sync_q[SYNC_STAGES-2:0], ~pwr_dn_ni};
        end
    end
    assign pd_req = pd_sync_q[SYNC_STAGES-1];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_RUN:   if (pd_req) state_d = PS_DRAIN;
            PS_DRAIN: if (cnt_q == DRAIN_LAST) state_d = PS_OFF;
            PS_OFF:   if (!pd_req) state_d = PS_WAKE;
            PS_WAKE: begin
                if (pd_req) begin
                    state_d = PS_DRAIN;
                end else if (cnt_q == WAKE_LAST) begin
                    state_d = PS_RUN;
                end
            end
            default:  state_d = PS_WAKE;
        endcase
    end

    // State register and its dwell counter.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= PS_WAKE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                cnt_q <= '0;
            end else if (state_q == PS_DRAIN || state_q == PS_WAKE) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Registered outputs, decoded from the next state.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pwr_ok_o <= 1'b0;
            osc_en_o <= 1'b1;
        end else begin
            pwr_ok_o <= (state_d == PS_RUN);
            osc_en_o <= (state_d != PS_OFF);
        end
    end
endmodule

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/1ps
module clkstop_ctrl #(
    parameter int CPU_OUTS     = 4,
    parameter int PCI_OUTS     = 7,
    parameter int AUX_OUTS     = 4,
    parameter int SYNC_STAGES  = 2,
    parameter int DRAIN_CYCLES = 4,
    parameter int WAKE_CYCLES  = 16
) (
    input  logic                rst_n,
    input  logic                cpu_clk,
    input  logic                pci_clk,
    input  logic                aux_clk,
    input  logic                cpu_stop_n,
    input  logic                pci_stop_n,
    input  logic                pwr_dn_n,
    output logic [CPU_OUTS-1:0] cpu_clk_out,
    output logic [PCI_OUTS-1:0] pci_clk_out,
    output logic                pci_free_out,
    output logic [AUX_OUTS-1:0] aux_clk_out,
    output logic                osc_pll_en
);
    logic pwr_ok;
    logic cpu_gated, pci_gated, aux_gated;

    clkstop_pwr_fsm #(
        .SYNC_STAGES (SYNC_STAGES),
        .DRAIN_CYCLES(DRAIN_CYCLES),
        .WAKE_CYCLES (WAKE_CYCLES)
    ) i_pwr (
        .clk_i    (aux_clk),
        .rst_ni   (rst_n),
        .pwr_dn_ni(pwr_dn_n),
        .pwr_ok_o (pwr_ok),
        .osc_en_o (osc_pll_en)
    );

    clkstop_gate #(.SYNC_STAGES(SYNC_STAGES)) i_gate_cpu (
        .clk_i(cpu_clk), .rst_ni(rst_n), .run_i(cpu_stop_n & pwr_ok), .clk_o(cpu_gated)
    );
    clkstop_gate #(.SYNC_STAGES(SYNC_STAGES)) i_gate_pci (
        .clk_i(pci_clk), .rst_ni(rst_n), .run_i(pci_stop_n & pwr_ok), .clk_o(pci_gated)
    );
    clkstop_gate #(.SYNC_STAGES(SYNC_STAGES)) i_gate_free (
        .clk_i(pci_clk), .rst_ni(rst_n), .run_i(pwr_ok), .clk_o(pci_free_out)
    );
    clkstop_gate #(.SYNC_STAGES(SYNC_STAGES)) i_gate_aux (
        .clk_i(aux_clk), .rst_ni(rst_n), .run_i(pwr_ok), .clk_o(aux_gated)
    );

    for (genvar g = 0; g < CPU_OUTS; g++) begin : g_cpu
        assign cpu_clk_out[g] = cpu_gated;
    end
    for (genvar g = 0; g < PCI_OUTS; g++) begin : g_pci
        assign pci_clk_out[g] = pci_gated;
    end
    for (genvar g = 0; g < AUX_OUTS; g++) begin : g_aux
        assign aux_clk_out[g] = aux_gated;
    end
endmodule

// File: rtl/clkstop_ctrl_chk.sv
`timescale 1ns/1ps
module clkstop_ctrl_chk (
    input logic rst_n,
    input logic cpu_clk,
    input logic pci_clk,
    input logic aux_clk,
    input logic cpu_stop_n,
    input logic pci_stop_n,
    input logic cpu_out0,
    input logic pci_out0,
    input logic free_out,
    input logic aux_out0,
    input logic osc_pll_en,
    input logic pwr_ok
);
    // R2: a stop request seen on three falling edges leaves the last high phase dark
    p_cpu_stop_hold_r2: assert property (@(negedge cpu_clk) disable iff (!rst_n)
        (!cpu_stop_n && $past(!cpu_stop_n) && $past(!cpu_stop_n, 2)) |-> !cpu_out0);

    // R3
    p_pci_stop_hold_r3: assert property (@(negedge pci_clk) disable iff (!rst_n)
        (!pci_stop_n && $past(!pci_stop_n) && $past(!pci_stop_n, 2)) |-> !pci_out0);

    // R4: with power up, the free clock is high in every high phase
    p_free_runs_r4: assert property (@(negedge pci_clk) disable iff (!rst_n)
        (pwr_ok && $past(pwr_ok) && $past(pwr_ok, 2)) |-> free_out);

    // R5: oscillator off only after every group has gone quiet
    p_osc_off_quiet_r5: assert property (@(posedge aux_clk) disable iff (!rst_n)
        !osc_pll_en |-> (!cpu_out0 && !pci_out0 && !free_out && !aux_out0));

    // R6: groups are released only after the oscillator has been on a while
    p_lock_before_run_r6: assert property (@(posedge aux_clk) disable iff (!rst_n)
        $rose(pwr_ok) |-> (osc_pll_en && $past(osc_pll_en) && $past(osc_pll_en, 2)));
endmodule

bind clkstop_ctrl clkstop_ctrl_chk i_clkstop_ctrl_chk (
    .rst_n     (rst_n),
    .cpu_clk   (cpu_clk),
    .pci_clk   (pci_clk),
    .aux_clk   (aux_clk),
    .cpu_stop_n(cpu_stop_n),
    .pci_stop_n(pci_stop_n),
    .cpu_out0  (cpu_clk_out[0]),
    .pci_out0  (pci_clk_out[0]),
    .free_out  (pci_free_out),
    .aux_out0  (aux_clk_out[0]),
    .osc_pll_en(osc_pll_en),
    .pwr_ok    (pwr_ok)
);

// File: tb/test_clkstop_ctrl.sv
`timescale 1ns/1ps
module test_clkstop_ctrl;
    localparam int  CPU_OUTS = 4;
    localparam int  PCI_OUTS = 7;
    localparam int  AUX_OUTS = 4;
    localparam int  DRAIN    = 4;
    localparam int  WAKE     = 16;
    localparam real AUX_PER  = 14.0;
    localparam real SETTLE   = (WAKE + DRAIN + 8) * AUX_PER;

    logic rst_n = 1'b0;
    logic cpu_clk = 1'b0, pci_clk = 1'b0, aux_clk = 1'b0;
    logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pwr_dn_n = 1'b1;
    logic [CPU_OUTS-1:0] cpu_clk_out;
    logic [PCI_OUTS-1:0] pci_clk_out;
    logic                pci_free_out;
    logic [AUX_OUTS-1:0] aux_clk_out;
    logic                osc_pll_en;

    int checks = 0, failures = 0, glitches = 0;
    int n_cpu = 0, n_pci = 0, n_free = 0, n_aux = 0;
    bit done = 1'b0;

    clkstop_ctrl #(
        .CPU_OUTS(CPU_OUTS), .PCI_OUTS(PCI_OUTS), .AUX_OUTS(AUX_OUTS),
        .SYNC_STAGES(2), .DRAIN_CYCLES(DRAIN), .WAKE_CYCLES(WAKE)
    ) i_clkstop_ctrl (
        .rst_n(rst_n), .cpu_clk(cpu_clk), .pci_clk(pci_clk), .aux_clk(aux_clk),
        .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pwr_dn_n(pwr_dn_n),
        .cpu_clk_out(cpu_clk_out), .pci_clk_out(pci_clk_out),
        .pci_free_out(pci_free_out), .aux_clk_out(aux_clk_out),
        .osc_pll_en(osc_pll_en)
    );

    always #2.0 cpu_clk = ~cpu_clk;
    initial begin #1.1; forever #4.0 pci_clk = ~pci_clk; end
    initial begin #0.7; forever #(AUX_PER / 2.0) aux_clk = ~aux_clk; end

    // Edge counters and edge-versus-source monitors (R7)
    always @(posedge cpu_clk_out[0]) begin n_cpu++; if (rst_n && !cpu_clk) glitches++; end
    always @(negedge cpu_clk_out[0]) if (rst_n && cpu_clk) glitches++;
    always @(posedge pci_clk_out[0]) begin n_pci++; if (rst_n && !pci_clk) glitches++; end
    always @(negedge pci_clk_out[0]) if (rst_n && pci_clk) glitches++;
    always @(posedge pci_free_out)   begin n_free++; if (rst_n && !pci_clk) glitches++; end
    always @(negedge pci_free_out)   if (rst_n && pci_clk) glitches++;
    always @(posedge aux_clk_out[0]) begin n_aux++; if (rst_n && !aux_clk) glitches++; end
    always @(negedge aux_clk_out[0]) if (rst_n && aux_clk) glitches++;

    function automatic bit exp_cpu(bit cs, bit ps, bit pd); return pd & cs; endfunction
    function automatic bit exp_pci(bit cs, bit ps, bit pd); return pd & ps; endfunction
    function automatic bit exp_free(bit cs, bit ps, bit pd); return pd; endfunction
    function automatic bit exp_aux(bit cs, bit ps, bit pd); return pd; endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic zero_counts();
        n_cpu = 0; n_pci = 0; n_free = 0; n_aux = 0;
    endtask

    // A group "runs" if it produced a rising edge in the window; a stopped one
    // must also sit low at the end of the window.
    task automatic observe(input bit cs, input bit ps, input bit pd);
        bit r;
        zero_counts();
        #60.3;
        r = exp_cpu(cs, ps, pd);
        chk((n_cpu > 0) == r && (r || cpu_clk_out == '0), "R2 cpu group", n_cpu, int'(r));
        r = exp_pci(cs, ps, pd);
        chk((n_pci > 0) == r && (r || pci_clk_out == '0), "R3 pci group", n_pci, int'(r));
        r = exp_free(cs, ps, pd);
        chk((n_free > 0) == r && (r || !pci_free_out), "R4 free pci", n_free, int'(r));
        r = exp_aux(cs, ps, pd);
        chk((n_aux > 0) == r && (r || aux_clk_out == '0), "R8 aux group", n_aux, int'(r));
        chk(osc_pll_en == pd, "R5 osc enable", int'(osc_pll_en), int'(pd));
    endtask

    task automatic apply(input bit cs, input bit ps, input bit pd);
        #3.3;
        cpu_stop_n = cs; pci_stop_n = ps; pwr_dn_n = pd;
        #(SETTLE);
        observe(cs, ps, pd);
    endtask

    initial begin
        #(100000.0);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'd20240611);
        // R1: reset and the lock wait that follows it
        #20.3;
        chk(cpu_clk_out == '0 && pci_clk_out == '0 && !pci_free_out && aux_clk_out == '0,
            "R1 outputs low in reset", int'(cpu_clk_out[0]), 0);
        chk(osc_pll_en == 1'b1, "R1 osc on in reset", int'(osc_pll_en), 1);
        rst_n = 1'b1;
        zero_counts();
        #((WAKE - 1) * AUX_PER);
        chk(n_cpu + n_pci + n_free + n_aux == 0, "R1 quiet after reset",
            n_cpu + n_pci + n_free + n_aux, 0);
        chk(osc_pll_en == 1'b1, "R1 osc on during wait", int'(osc_pll_en), 1);
        #(SETTLE);
        observe(1, 1, 1);

        // Directed corners: each stop alone, both, power-down overriding both
        apply(0, 1, 1);   // R2, R4 pci unaffected
        apply(1, 1, 1);   // R2 restart
        apply(1, 0, 1);   // R3, R4 free keeps going
        apply(0, 0, 1);
        apply(1, 1, 0);   // R5
        apply(0, 0, 0);   // R5 with stops active

        // R6: quiet window after oscillator re-enable
        #3.3;
        cpu_stop_n = 1'b1; pci_stop_n = 1'b1; pwr_dn_n = 1'b1;
        @(posedge osc_pll_en);
        zero_counts();
        #((WAKE - 1) * AUX_PER);
        chk(n_cpu + n_pci + n_free + n_aux == 0, "R6 quiet during lock wait",
            n_cpu + n_pci + n_free + n_aux, 0);
        chk(osc_pll_en == 1'b1, "R6 osc on during lock wait", int'(osc_pll_en), 1);
        #(SETTLE);
        observe(1, 1, 1);

        // Short power-down pulse returning during drain
        #3.3; pwr_dn_n = 1'b0;
        #(2.5 * AUX_PER); pwr_dn_n = 1'b1;
        #(SETTLE);
        observe(1, 1, 1);

        // Seeded random walk
        for (int i = 0; i < 20; i++) begin
            logic [31:0] r;
            r = $urandom;
            apply(r[2], r[3], r[1:0] != 2'b00);
        end

        chk(glitches == 0, "R7 edges follow source clock", glitches, 0);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule